// File: doc/BRIEF.md
# Transmit Checksum Insertion Engine

This block sits in an Ethernet transmit path. It takes one frame as a byte stream and stores all of it. While the bytes arrive, it works out what the frame carries. When the last byte has been taken, it spends one cycle settling the checksums. It then sends the stored frame back out, byte for byte, with the protocol checksums written into their fields. A two-bit mode travels with the first byte of each frame and selects how much work is done:

- Mode 0 passes the frame through untouched.
- Mode 1 writes only the IPv4 header checksum.
- Modes 2 and 3 also write the TCP, UDP or ICMP checksum. Mode 2 expects software to have put the pseudo-header sum into the checksum field beforehand. Mode 3 expects that field to be zero and adds the pseudo-header itself.

The engine reads the EtherType to find the IP version. It reads the IPv4 protocol field or the IPv6 next-header field to find the layer-4 protocol. It takes the extent of the segment from the IP length field. Bytes after the datagram (Ethernet padding) are replayed unchanged. The engine accepts no new frame while it is replaying one.

Top module: `csum_insert_top`

## Requirements
- R1: The mode is taken from `inMode` on the first byte of a frame, and only when `inFirst` is high on that byte. Without `inFirst` the frame is handled as mode 0. The value of `inMode` on later bytes of the frame has no effect.
- R2: In mode 0 every output byte equals the input byte at the same position.
- R3: In mode 1, for an IPv4 frame, bytes 24 and 25 (MSB first) carry the one's complement of the 16-bit one's-complement sum of the IHL*4 header bytes, with the checksum field counted as zero. Its incoming value has no effect. IPv6 and non-IP frames pass unchanged in mode 1.
- R4: In mode 2 the layer-4 checksum is the complemented one's-complement sum of the whole segment, including whatever the checksum field already holds.
- R5: In mode 3 the same sum also includes the pseudo-header: source and destination addresses, the protocol number and the layer-4 length. ICMP over IPv4 takes no pseudo-header.
- R6: In modes 2 and 3 an IPv4 frame also gets its header checksum as in R3.
- R7: EtherType 0x0800 means IPv4 and 0x86DD means IPv6. The IPv4 header starts at byte 14, and the IPv6 segment starts at byte 54. Protocol 6 is TCP, 17 is UDP, and 1 (IPv4) or 58 (IPv6) is ICMP. The checksum field sits at segment offset 16, 6 or 2, MSB first. Any other EtherType or protocol leaves the layer-4 bytes unchanged.
- R8: A UDP checksum that works out to 0x0000 is sent as 0xFFFF.
- R9: The segment length is the IPv4 total length minus IHL*4, or the IPv6 payload length. An odd final byte is summed as the high byte of a word whose low byte is zero. Bytes after the datagram are not summed and pass unchanged.
- R10: `inReady` is high while the engine collects a frame. The cycle after the last byte is accepted, both `inReady` and `outValid` are low. From the next cycle the frame comes out on consecutive cycles, and `outLast` marks the final byte. `inReady` returns high the cycle after that byte.
- R11: The output holds exactly as many bytes as the input frame, in the same order.
- R12: After reset `outValid` and `outLast` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input byte present |
| inData | input | 8 | Input byte |
| inFirst | input | 1 | Marks the first segment; qualifies `inMode` |
| inMode | input | 2 | Checksum mode 0..3 |
| inLast | input | 1 | Marks the final byte of the frame |
| inReady | output | 1 | Engine is collecting and takes input bytes |
| outValid | output | 1 | Output byte present |
| outData | output | 8 | Output byte with checksums patched |
| outLast | output | 1 | Final output byte of the frame |

## Verification
The assertions assume four things about every frame:
- It fits in the buffer.
- Its IP headers are well formed: IHL is at least 5, and the length fields match the bytes actually sent.
- Any layer-4 checksum field falls inside the segment.
- Input is offered only while `inReady` is high.

The stimulus builds every frame with its own generator, so header lengths, segment lengths and padding always agree. It offers the next frame only after the previous replay has finished.

// File: rtl/csum_pkg.sv
`timescale 1ns/1ps
package csum_pkg;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_FINISH  = 2'd1,
    ST_REPLAY  = 2'd2
  } ctrl_state_e;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic capture;   // accept the byte on inData
    logic finalize;  // fold the sums and latch the patch values
    logic replay;    // step the read pointer
    logic restart;   // clear everything ready for the next frame
  } ctrl_strobe_t;

  localparam logic [15:0] ETH_IPV4    = 16'h0800;
  localparam logic [15:0] ETH_IPV6    = 16'h86DD;
  localparam logic [7:0]  PROTO_TCP   = 8'd6;
  localparam logic [7:0]  PROTO_UDP   = 8'd17;
  localparam logic [7:0]  PROTO_ICMP4 = 8'd1;
  localparam logic [7:0]  PROTO_ICMP6 = 8'd58;

  // One's-complement fold of a 32-bit accumulator to 16 bits.
  function automatic logic [15:0] fold32(input logic [31:0] v);
    logic [16:0] t;
    t = {1'b0, v[15:0]} + {1'b0, v[31:16]};
    t = {1'b0, t[15:0]} + {16'd0, t[16]};
    return t[15:0];
  endfunction

endpackage

// File: rtl/csum_ctrl.sv
`timescale 1ns/1ps
module csum_ctrl
  import csum_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inLast,
  input  logic         rdAtEnd,
  output logic         inReady,
  output logic         outValid,
  output logic         outLast,
  output ctrl_strobe_t strb
);

  ctrl_state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_COLLECT;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_COLLECT: begin
        strb.capture = inValid;
        if (inValid && inLast) nextState = ST_FINISH;
      end
      ST_FINISH: begin
        strb.finalize = 1'b1;
        nextState     = ST_REPLAY;
      end
      ST_REPLAY: begin
        strb.replay = 1'b1;
        if (rdAtEnd) begin
          strb.restart = 1'b1;
          nextState    = ST_COLLECT;
        end
      end
      default: nextState = ST_COLLECT;
    endcase
  end

  assign inReady  = (state == ST_COLLECT);
  assign outValid = (state == ST_REPLAY);
  assign outLast  = outValid && rdAtEnd;

  // R10: input and output phases never overlap
  assert_no_overlap_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  // R10: after the final byte the engine is idle and ready again
  assert_ready_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    outLast |=> (!outValid && inReady));

  // R10: a frame's last input byte is followed by a gap cycle
  assert_gap_after_input_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid && inLast) |=> (!inReady && !outValid));

endmodule

// File: rtl/csum_datapath.sv
`timescale 1ns/1ps
module csum_datapath
  import csum_pkg::*;
#(
  parameter int MAX_BYTES = 1536
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strb,
  input  logic [7:0]   inData,
  input  logic         inFirst,
  input  logic [1:0]   inMode,
  output logic [7:0]   outData,
  output logic         rdAtEnd
);

  localparam int AW = $clog2(MAX_BYTES);
  localparam int PW = AW + 1;
  localparam int XW = 17;

  logic [7:0]    frameMem [MAX_BYTES];
  logic [PW-1:0] wrPtr, rdPtr, lastPtr;
  logic [1:0]    modeQ;
  logic [15:0]   etherQ, ipLenQ;
  logic [3:0]    ihlQ;
  logic [7:0]    protoQ;
  logic [31:0]   hdrAcc, addrAcc, l4Acc;
  logic [15:0]   hdrCsumQ, l4CsumQ;
  logic          patchHdrQ, patchL4Q;
  logic [XW-1:0] csumPosQ;

  // ---------------- classification of the frame under collection -------
  logic [XW-1:0] pos, hdrBytes, l4Start, l4End;
  logic [15:0]   l4Len, byteWord;
  logic          isV4, isV6, isTcp, isUdp, isIcmp, l4Known;
  logic          hdrWin, addrWin, l4Win;

  always_comb begin
    pos      = XW'(wrPtr);
    isV4     = (etherQ == ETH_IPV4);
    isV6     = (etherQ == ETH_IPV6);
    hdrBytes = XW'({ihlQ, 2'b00});
    l4Start  = isV4 ? (XW'(14) + hdrBytes) : XW'(54);
    l4End    = isV4 ? (XW'(14) + XW'(ipLenQ)) : (XW'(54) + XW'(ipLenQ));
    l4Len    = isV4 ? (ipLenQ - 16'({ihlQ, 2'b00})) : ipLenQ;
    isTcp    = (protoQ == PROTO_TCP);
    isUdp    = (protoQ == PROTO_UDP);
    isIcmp   = isV4 ? (protoQ == PROTO_ICMP4) : (protoQ == PROTO_ICMP6);
    l4Known  = (isV4 || isV6) && (isTcp || isUdp || isIcmp);
    byteWord = pos[0] ? {8'h00, inData} : {inData, 8'h00};
    // byte 14 holds IHL itself, so it is always in the header
    hdrWin   = isV4 && ((pos == XW'(14)) ||
                        ((pos > XW'(14)) && (pos < XW'(14) + hdrBytes)))
                    && (pos != XW'(24)) && (pos != XW'(25));
    addrWin  = isV4 ? ((pos >= XW'(26)) && (pos < XW'(34)))
             : isV6 ? ((pos >= XW'(22)) && (pos < XW'(54))) : 1'b0;
    l4Win    = (isV4 || isV6) && (pos > XW'(19))
               && (pos >= l4Start) && (pos < l4End);
  end

  // ---------------- final checksum values ---------------------------------
  logic        usePseudo;
  logic [31:0] l4Total;
  logic [15:0] l4Csum;

  always_comb begin
    usePseudo = (modeQ == 2'd3) && !(isV4 && isIcmp);
    l4Total   = l4Acc + (usePseudo ? (addrAcc + 32'(protoQ) + 32'(l4Len)) : 32'd0);
    l4Csum    = ~fold32(l4Total);
    if (isUdp && (l4Csum == 16'h0000)) l4Csum = 16'hFFFF;
  end

  // ---------------- frame storage -----------------------------------------
  always_ff @(posedge clk) begin
    if (strb.capture && (wrPtr < PW'(MAX_BYTES)))
      frameMem[wrPtr[AW-1:0]] <= inData;
  end

  // ---------------- parse, accumulate, finalize, replay --------------------
  always_ff @(posedge clk) begin
    if (!rstN || strb.restart) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      modeQ   <= 2'd0;
      etherQ  <= 16'd0;
      ipLenQ  <= 16'd0;
      ihlQ    <= 4'd0;
      protoQ  <= 8'd0;
      hdrAcc  <= 32'd0;
      addrAcc <= 32'd0;
      l4Acc   <= 32'd0;
    end else begin
      if (strb.capture) begin
        wrPtr <= wrPtr + PW'(1);
        if (pos == XW'(0))  modeQ        <= inFirst ? inMode : 2'd0;
        if (pos == XW'(12)) etherQ[15:8] <= inData;
        if (pos == XW'(13)) etherQ[7:0]  <= inData;
        if (isV4) begin
          if (pos == XW'(14)) ihlQ         <= inData[3:0];
          if (pos == XW'(16)) ipLenQ[15:8] <= inData;
          if (pos == XW'(17)) ipLenQ[7:0]  <= inData;
          if (pos == XW'(23)) protoQ       <= inData;
        end
        if (isV6) begin
          if (pos == XW'(18)) ipLenQ[15:8] <= inData;
          if (pos == XW'(19)) ipLenQ[7:0]  <= inData;
          if (pos == XW'(20)) protoQ       <= inData;
        end
        if (hdrWin)  hdrAcc  <= hdrAcc  + 32'(byteWord);
        if (addrWin) addrAcc <= addrAcc + 32'(byteWord);
        if (l4Win)   l4Acc   <= l4Acc   + 32'(byteWord);
      end
      if (strb.replay) rdPtr <= rdPtr + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastPtr   <= '0;
      hdrCsumQ  <= 16'd0;
      l4CsumQ   <= 16'd0;
      patchHdrQ <= 1'b0;
      patchL4Q  <= 1'b0;
      csumPosQ  <= '0;
    end else if (strb.finalize) begin
      lastPtr   <= wrPtr - PW'(1);
      hdrCsumQ  <= ~fold32(hdrAcc);
      l4CsumQ   <= l4Csum;
      patchHdrQ <= isV4 && (modeQ != 2'd0);
      patchL4Q  <= l4Known && modeQ[1];
      csumPosQ  <= l4Start + (isTcp ? XW'(16) : isUdp ? XW'(6) : XW'(2));
    end
  end

  // ---------------- output byte with patches ------------------------------
  logic [XW-1:0] rdPos;
  always_comb begin
    rdPos   = XW'(rdPtr);
    outData = frameMem[rdPtr[AW-1:0]];
    if (patchHdrQ && (rdPos == XW'(24))) outData = hdrCsumQ[15:8];
    if (patchHdrQ && (rdPos == XW'(25))) outData = hdrCsumQ[7:0];
    if (patchL4Q && (rdPos == csumPosQ))          outData = l4CsumQ[15:8];
    if (patchL4Q && (rdPos == csumPosQ + XW'(1))) outData = l4CsumQ[7:0];
  end

  assign rdAtEnd = (rdPtr == lastPtr);

  // R11: frames never exceed the buffer
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> (wrPtr < PW'(MAX_BYTES)));

  // R1: the latched mode ignores inMode after the first byte
  assert_mode_held_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && (wrPtr != '0)) |=> $stable(modeQ));

  // R11: replay runs on consecutive cycles until the final byte
  assert_replay_contiguous_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.replay && !rdAtEnd) |=> strb.replay);

  // R7: the layer-4 field never overlaps the IPv4 header checksum
  assert_patch_sites_apart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (patchHdrQ && patchL4Q) |-> (csumPosQ > XW'(25)));

endmodule

// File: rtl/csum_insert_top.sv
`timescale 1ns/1ps
module csum_insert_top
  import csum_pkg::*;
#(
  parameter int MAX_BYTES = 1536
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       inFirst,
  input  logic [1:0] inMode,
  input  logic       inLast,
  output logic       inReady,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outLast
);

  ctrl_strobe_t strb;
  logic         rdAtEnd;

  csum_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .rdAtEnd  (rdAtEnd),
    .inReady  (inReady),
    .outValid (outValid),
    .outLast  (outLast),
    .strb     (strb)
  );

  csum_datapath #(.MAX_BYTES(MAX_BYTES)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .inData  (inData),
    .inFirst (inFirst),
    .inMode  (inMode),
    .outData (outData),
    .rdAtEnd (rdAtEnd)
  );

endmodule

// File: tb/csum_insert_top_tb_top.sv
`timescale 1ns/1ps
module csum_insert_top_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inFirst = 1'b0;
  logic [1:0] inMode = 2'd0;
  logic       inLast = 1'b0;
  logic       inReady, outValid, outLast;
  logic [7:0] outData;

  always #4 clk = ~clk;  // 125 MHz

  csum_insert_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inFirst(inFirst), .inMode(inMode), .inLast(inLast),
    .inReady(inReady), .outValid(outValid), .outData(outData), .outLast(outLast)
  );

  int total = 0;
  int bad   = 0;

  logic [7:0] txBuf  [0:2047];
  logic [7:0] expBuf [0:2047];
  logic [7:0] rxBuf  [0:2047];
  int txLen, rxLen, l4Off, l4LenG, csOff, ihlG, protoG;
  bit isV4g, isV6g, isUdpG, isIcmpG, hasL4;
  logic [31:0] rnd;

  // mode, kind, ihl, payload length, padding, seed
  // kinds: 0 v4 TCP, 1 v4 UDP, 2 v4 ICMP, 3 v6 TCP, 4 v6 UDP, 5 v6 ICMP,
  //        6 non-IP, 7 v4 unknown protocol
  localparam int NVEC = 13;
  localparam logic [31:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 4'd5, 8'd20, 8'd0,  7'd11},  // R2
    {2'd1, 3'd1, 4'd5, 8'd13, 8'd0,  7'd12},  // R3
    {2'd1, 3'd4, 4'd5, 8'd10, 8'd0,  7'd13},  // R3 IPv6 untouched
    {2'd2, 3'd0, 4'd5, 8'd31, 8'd0,  7'd14},  // R4 R6
    {2'd2, 3'd4, 4'd5, 8'd10, 8'd0,  7'd15},  // R4
    {2'd3, 3'd1, 4'd5, 8'd17, 8'd0,  7'd16},  // R5 R9 odd
    {2'd3, 3'd3, 4'd5, 8'd40, 8'd0,  7'd17},  // R5
    {2'd3, 3'd2, 4'd5, 8'd12, 8'd0,  7'd18},  // R5 ICMPv4
    {2'd3, 3'd5, 4'd5, 8'd9,  8'd0,  7'd19},  // R5 R7 ICMPv6
    {2'd3, 3'd6, 4'd5, 8'd20, 8'd0,  7'd20},  // R7 non-IP
    {2'd3, 3'd7, 4'd5, 8'd16, 8'd0,  7'd21},  // R7 unknown protocol
    {2'd3, 3'd0, 4'd6, 8'd6,  8'd10, 7'd22},  // R9 options + padding
    {2'd2, 3'd1, 4'd7, 8'd1,  8'd3,  7'd23}   // R9 R6
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] rbyte();
    rnd = rnd * 32'd1103515245 + 32'd12345;
    return rnd[23:16];
  endfunction

  function automatic logic [31:0] sumBytes(input int from, input int upto);
    logic [31:0] s = 32'd0;
    for (int i = from; i < upto; i += 2)
      s = s + 32'({txBuf[i], ((i + 1 < upto) ? txBuf[i+1] : 8'h00)});
    return s;
  endfunction

  function automatic logic [15:0] fold16(input logic [31:0] v);
    logic [31:0] t = v;
    while (t[31:16] != 16'd0) t = {16'd0, t[15:0]} + {16'd0, t[31:16]};
    return t[15:0];
  endfunction

  function automatic logic [31:0] pseudoSum();
    if (isV4g) return sumBytes(26, 34) + 32'(protoG) + 32'(l4LenG);
    return sumBytes(22, 54) + 32'(protoG) + 32'(l4LenG);
  endfunction

  task automatic buildFrame(input int kind, input int ihl, input int pay,
                            input int pad, input int seed, input int mode);
    int hdrLen, p;
    logic [15:0] f;
    rnd = 32'(seed) * 32'd7919 + 32'd1;
    for (int i = 0; i < 12; i++) txBuf[i] = rbyte();
    isV4g = (kind <= 2) || (kind == 7);
    isV6g = (kind >= 3) && (kind <= 5);
    isUdpG = (kind == 1) || (kind == 4);
    isIcmpG = (kind == 2) || (kind == 5);
    hasL4 = (kind <= 5);
    ihlG = ihl;
    case (kind)
      0, 3:    protoG = 6;
      1, 4:    protoG = 17;
      2:       protoG = 1;
      5:       protoG = 58;
      default: protoG = 47;
    endcase
    hdrLen = (protoG == 6) ? 20 : (protoG == 47) ? 4 : 8;
    l4LenG = hdrLen + pay;
    if (kind == 6) begin
      txBuf[12] = 8'h88; txBuf[13] = 8'hB5;
      txLen = 14 + 46 + pay;
      for (int i = 14; i < txLen; i++) txBuf[i] = rbyte();
      l4Off = 0; csOff = 0;
      return;
    end
    if (isV4g) begin
      txBuf[12] = 8'h08; txBuf[13] = 8'h00;
      txBuf[14] = 8'h40 | 8'(ihl);
      txBuf[15] = 8'h00;
      txBuf[16] = 8'((ihl * 4 + l4LenG) >> 8);
      txBuf[17] = 8'(ihl * 4 + l4LenG);
      txBuf[18] = 8'(seed); txBuf[19] = rbyte();
      txBuf[20] = 8'h40; txBuf[21] = 8'h00; txBuf[22] = 8'd64;
      txBuf[23] = 8'(protoG);
      txBuf[24] = 8'hBE; txBuf[25] = 8'hEF;  // stale value, must not matter
      for (int i = 26; i < 14 + ihl * 4; i++) txBuf[i] = rbyte();
      l4Off = 14 + ihl * 4;
    end else begin
      txBuf[12] = 8'h86; txBuf[13] = 8'hDD;
      txBuf[14] = 8'h60; txBuf[15] = 8'h00; txBuf[16] = 8'h00; txBuf[17] = 8'h00;
      txBuf[18] = 8'(l4LenG >> 8); txBuf[19] = 8'(l4LenG);
      txBuf[20] = 8'(protoG); txBuf[21] = 8'd64;
      for (int i = 22; i < 54; i++) txBuf[i] = rbyte();
      l4Off = 54;
    end
    for (int i = 0; i < l4LenG; i++) txBuf[l4Off + i] = rbyte();
    p = (protoG == 6) ? 16 : (protoG == 17) ? 6 : 2;
    csOff = l4Off + p;
    if (isUdpG) begin
      txBuf[l4Off + 4] = 8'(l4LenG >> 8);
      txBuf[l4Off + 5] = 8'(l4LenG);
    end
    if (hasL4 && mode == 2) begin
      f = (isV4g && isIcmpG) ? 16'h0000 : fold16(pseudoSum());
      txBuf[csOff] = f[15:8]; txBuf[csOff + 1] = f[7:0];
    end else if (hasL4 && mode == 3) begin
      txBuf[csOff] = 8'h00; txBuf[csOff + 1] = 8'h00;
    end
    txLen = l4Off + l4LenG + pad;
    for (int i = l4Off + l4LenG; i < txLen; i++) txBuf[i] = rbyte();
  endtask

  task automatic buildExpected(input int expMode);
    logic [31:0] s;
    logic [15:0] c;
    for (int i = 0; i < txLen; i++) expBuf[i] = txBuf[i];
    if (isV4g && expMode != 0) begin
      s = 32'd0;
      for (int i = 14; i < 14 + ihlG * 4; i += 2)
        if (i != 24) s = s + 32'({txBuf[i], txBuf[i+1]});
      c = ~fold16(s);
      expBuf[24] = c[15:8]; expBuf[25] = c[7:0];
    end
    if (hasL4 && expMode >= 2) begin
      s = sumBytes(l4Off, l4Off + l4LenG);
      if (expMode == 3 && !(isV4g && isIcmpG)) s = s + pseudoSum();
      c = ~fold16(s);
      if (isUdpG && c == 16'h0000) c = 16'hFFFF;
      expBuf[csOff] = c[15:8]; expBuf[csOff + 1] = c[7:0];
    end
  endtask

  task automatic runFrame(input logic [1:0] drvMode, input bit useFirst,
                          input logic [1:0] laterMode, input int expMode,
                          input string req);
    int mis;
    bit lastSeen;
    buildExpected(expMode);
    for (int i = 0; i < txLen; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData  = txBuf[i];
      inFirst = useFirst && (i == 0);
      inMode  = (i == 0) ? drvMode : laterMode;
      inLast  = (i == txLen - 1);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0; inFirst = 1'b0; inData = 8'h00;
    // R10: gap cycle after the last accepted byte
    check(!outValid && !inReady, "R10", "gap cycle", int'({outValid, inReady}), 0);
    @(negedge clk);
    check(outValid === 1'b1, "R10", "replay start", int'(outValid), 1);
    rxLen = 0;
    lastSeen = 1'b0;
    while (outValid === 1'b1 && rxLen < 2048) begin
      rxBuf[rxLen] = outData;
      rxLen++;
      lastSeen = outLast;
      @(negedge clk);
      if (lastSeen) break;
    end
    check(lastSeen, "R10", "last marker", int'(lastSeen), 1);
    check(rxLen == txLen, "R11", "byte count", rxLen, txLen);
    mis = -1;
    for (int i = 0; i < txLen && i < rxLen; i++)
      if (mis < 0 && rxBuf[i] !== expBuf[i]) mis = i;
    if (mis >= 0)
      check(1'b0, req, $sformatf("byte %0d", mis), int'(rxBuf[mis]), int'(expBuf[mis]));
    else
      check(1'b1, req, "frame content", 0, 0);
    check(!outValid && inReady, "R10", "ready after frame", int'({outValid, inReady}), 1);
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [1:0]  m;
    logic [31:0] s;
    logic [15:0] w;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12: reset state
    check(!outValid && !outLast && inReady, "R12", "reset state",
          int'({outValid, outLast, inReady}), 1);

    // Table-driven frames: mode 0 R2, 1 R3, 2 R4/R6, 3 R5/R6, plus R7/R9 shapes
    for (int k = 0; k < NVEC; k++) begin
      m = VEC[k][31:30];
      buildFrame(int'(VEC[k][29:27]), int'(VEC[k][26:23]), int'(VEC[k][22:15]),
                 int'(VEC[k][14:7]), int'(VEC[k][6:0]), int'(m));
      case (m)
        2'd0: runFrame(m, 1'b1, m, 0, "R2");
        2'd1: runFrame(m, 1'b1, m, 1, "R3");
        2'd2: runFrame(m, 1'b1, m, 2, "R4");
        default: runFrame(m, 1'b1, m, 3, "R5");
      endcase
    end

    // R1: a mode change after the first byte is ignored
    buildFrame(1, 5, 14, 0, 40, 3);
    runFrame(2'd3, 1'b1, 2'd0, 3, "R1");

    // R1: without the first-segment marker the frame is bypassed
    buildFrame(0, 5, 14, 0, 41, 3);
    runFrame(2'd3, 1'b0, 2'd3, 0, "R1");

    // R6: IPv4 header checksum also written in mode 2, IPv6 header not needed
    buildFrame(2, 5, 4, 0, 42, 2);
    runFrame(2'd2, 1'b1, 2'd2, 2, "R6");

    // R8: UDP sum of zero is sent as all ones
    buildFrame(1, 5, 6, 0, 43, 3);
    txBuf[l4Off + 8] = 8'h00; txBuf[l4Off + 9] = 8'h00;
    s = sumBytes(l4Off, l4Off + l4LenG) + pseudoSum();
    w = 16'hFFFF - fold16(s);
    txBuf[l4Off + 8] = w[15:8]; txBuf[l4Off + 9] = w[7:0];
    runFrame(2'd3, 1'b1, 2'd3, 3, "R8");
    check(rxBuf[csOff] == 8'hFF && rxBuf[csOff + 1] == 8'hFF, "R8", "zero to FFFF",
          int'({rxBuf[csOff], rxBuf[csOff + 1]}), 65535);

    // R9: trailing padding after a TCP segment passes unchanged
    buildFrame(0, 5, 3, 20, 44, 3);
    runFrame(2'd3, 1'b1, 2'd3, 3, "R9");
    check(rxBuf[txLen - 1] == txBuf[txLen - 1], "R9", "pad byte",
          int'(rxBuf[txLen - 1]), int'(txBuf[txLen - 1]));

    finishRun();
  end

endmodule